// File: doc/BRIEF.md
# Extended Inner Bank Register File

This block holds the inner bank-switch registers that a console cartridge controller exposes in the upper half of the CPU address space. The CPU writes a bank-select byte, then a bank-data byte, to load one of twelve bank registers. It can also write a two-bit nametable arrangement code. From these registers and the upper address lines of the current access, the block produces the inner PRG bank number for CPU A14..A13 and the inner CHR bank number for PPU A12..A10. Outer bank logic elsewhere combines these numbers with its own base bits.

An external flag selects one of two mapping schemes. With the flag clear, the block behaves like the classic scheme. Two CHR registers each cover a 2 KiB pair and four cover single 1 KiB slots. Two PRG windows are switchable and the other two are pinned to the last two banks. With the flag set, four additional registers come into use. Every 1 KiB CHR slot and every 8 KiB PRG window then gets its own register. The additional registers are written and held whether or not the flag is set, so turning the flag on takes effect on the next access. The scanline interrupt counter is not part of this block.

Top module: `ext_bank_regfile`

## Requirements
- R1: A write is decoded through the mask $E003. Only $8000 (select), $8001 (data) and $A000 (arrangement) take effect. Any write with A15 low, with A1 high (for example $9FFF or $8002), or to $C000-$FFFF changes nothing.
- R2: The select byte places the register index in bits 3:0, the PRG window swap in bit 6, and the CHR half invert in bit 7. The invert bit XORs PPU A12 before slot lookup.
- R3: A data write stores wr_data into the register named by the current index when the index is 0 to 11. Indices 12 to 15 leave every register unchanged.
- R4: After reset the registers 0..11 hold $00,$02,$04,$05,$06,$07,$00,$01,$FE,$FF,$FF,$FF. The select byte and the arrangement code are zero.
- R5: With the extended flag clear, effective slots 0/1 read register 0 with bit 0 replaced by the slot LSB. Slots 2/3 do the same with register 1. Slots 4..7 read registers 2..5.
- R6: With the extended flag set, effective slots 0..7 read registers 0, 10, 1, 11, 2, 3, 4, 5 respectively.
- R7: With the flag clear, window 1 reads register 7 and window 3 reads the last bank $FF. Window 0 reads register 6 and window 2 reads $FE; with the swap bit set, these two exchange.
- R8: With the flag set, windows 0..3 read registers 6, 7, 8, 9. With the swap bit set, windows 0 and 2 read registers 8 and 6.
- R9: A write to $A000 loads wr_data[1:0] into the arrangement output (0 vertical, 1 horizontal).
- R10: Registers 8..11 are loaded while the extended flag is clear, and take effect in the first access after the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_mode | input | 1 | Extended mapping flag from the separate mode register |
| cpu_win | input | 2 | CPU A14..A13 of the current access |
| ppu_slot | input | 3 | PPU A12..A10 of the current access |
| prg_bank | output | 8 | Inner 8 KiB PRG bank number |
| chr_bank | output | 8 | Inner 1 KiB CHR bank number |
| mirror | output | 2 | Nametable arrangement code |

## Verification
The hardest case to reach is a change of the extended flag after registers 8..11 have been loaded while the flag was clear. The stimulus loads those registers with distinct values in standard mode and checks that no output shows them. It then raises the flag and sweeps every window and slot in the next cycles. Masked-out addresses are exercised between a select write and its data write. A stray write that moved the index would then send the following data byte to the wrong register, and the sweep exposes this.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
    localparam int BANK_W   = 8;
    localparam int NUM_REGS = 12;
    localparam int IDX_W    = 4;
    localparam int WIN_W    = 2;
    localparam int SLOT_W   = 3;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        logic             chr_inv;
        logic             prg_swap;
        logic [1:0]       unused;
        logic [IDX_W-1:0] idx;
    } sel_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_DATA,
        ACC_MIR
    } acc_t;

    localparam bank_t LAST_BANK = '1;
    localparam bank_t NEXT_LAST = LAST_BANK - bank_t'(1);

    function automatic bank_t power_on(input int i);
        case (i)
            0: power_on = bank_t'(8'h00);
            1: power_on = bank_t'(8'h02);
            2: power_on = bank_t'(8'h04);
            3: power_on = bank_t'(8'h05);
            4: power_on = bank_t'(8'h06);
            5: power_on = bank_t'(8'h07);
            6: power_on = bank_t'(8'h00);
            7: power_on = bank_t'(8'h01);
            8: power_on = NEXT_LAST;
            default: power_on = LAST_BANK;
        endcase
    endfunction

    function automatic acc_t classify(input logic [15:0] a);
        if (!a[15] || a[1]) return ACC_NONE;
        case ({a[14:13], a[0]})
            3'b000:  return ACC_SEL;
            3'b001:  return ACC_DATA;
            3'b010:  return ACC_MIR;
            default: return ACC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/xb_decode.sv
module xb_decode
    import xbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    output sel_t        sel_o,
    output logic [1:0]  mir_o,
    output logic        data_we_o
);
    acc_t acc;
    sel_t sel_q;
    logic [1:0] mir_q;

    assign acc = wr_en ? classify(wr_addr) : ACC_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            mir_q <= 2'b00;
        end else begin
            if (acc == ACC_SEL) sel_q <= sel_t'(wr_data);
            if (acc == ACC_MIR) mir_q <= wr_data[1:0];
        end
    end

    assign sel_o     = sel_q;
    assign mir_o     = mir_q;
    assign data_we_o = (acc == ACC_DATA);

    // R1: a write with A1 set leaves select and arrangement untouched
    p_masked_write_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15] && wr_addr[1]) |=> ($stable(sel_q) && $stable(mir_q)));

    // R9: arrangement follows a write to $A000
    p_mirror_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 16'hA000) |=> (mir_o == $past(wr_data[1:0])));
endmodule

// File: rtl/xb_store.sv
module xb_store
    import xbank_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  bank_t                          val,
    output logic [NUM_REGS-1:0][BANK_W-1:0] regs_o
);
    logic [NUM_REGS-1:0][BANK_W-1:0] regs_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= power_on(i);
            else if (we && idx == IDX_W'(i))
                regs_q[i] <= val;
        end
    end

    assign regs_o = regs_q;

    // R3: indices past the last register change nothing
    p_high_index_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (we && idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_q));

    // R4: power-on contents of the fixed-bank and pair registers
    p_poweron_values_r4: assert property (@(posedge clk)
        rst |=> (regs_q[8] == NEXT_LAST && regs_q[9] == LAST_BANK && regs_q[1] == bank_t'(8'h02)));
endmodule

// File: rtl/xb_chr_map.sv
module xb_chr_map
    import xbank_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ext_mode,
    input  logic                            chr_inv,
    input  logic [SLOT_W-1:0]               slot,
    input  logic [NUM_REGS-1:0][BANK_W-1:0] regs,
    output bank_t                           chr_o
);
    logic [SLOT_W-1:0] eff;
    bank_t pick;

    assign eff = slot ^ {chr_inv, {(SLOT_W-1){1'b0}}};

    always_comb begin
        if (ext_mode) begin
            case (eff)
                3'd0: pick = regs[0];
                3'd1: pick = regs[10];
                3'd2: pick = regs[1];
                3'd3: pick = regs[11];
                default: pick = regs[32'(eff) - 2];
            endcase
        end else begin
            case (eff)
                3'd0, 3'd1: pick = {regs[0][BANK_W-1:1], eff[0]};
                3'd2, 3'd3: pick = {regs[1][BANK_W-1:1], eff[0]};
                default:    pick = regs[32'(eff) - 2];
            endcase
        end
    end

    assign chr_o = pick;

    // R5: in standard mode the pair slots carry the slot LSB as bank LSB
    p_pair_lsb_r5: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && !eff[2]) |-> (chr_o[0] == eff[0]));

    // R6: in extended mode slot 1 is served by register 10
    p_ext_slot1_r6: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && eff == 3'd1) |-> (chr_o == regs[10]));
endmodule

// File: rtl/xb_prg_map.sv
module xb_prg_map
    import xbank_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ext_mode,
    input  logic                            prg_swap,
    input  logic [WIN_W-1:0]                win,
    input  logic [NUM_REGS-1:0][BANK_W-1:0] regs,
    output bank_t                           prg_o
);
    bank_t low_pick, high_pick, pick;

    always_comb begin
        low_pick  = ext_mode ? regs[8] : NEXT_LAST;
        high_pick = ext_mode ? regs[9] : LAST_BANK;
        case (win)
            2'd0: pick = prg_swap ? low_pick : regs[6];
            2'd1: pick = regs[7];
            2'd2: pick = prg_swap ? regs[6] : low_pick;
            default: pick = high_pick;
        endcase
    end

    assign prg_o = pick;

    // R7: standard mode pins the top window to the last bank
    p_fixed_top_r7: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && win == 2'd3) |-> (prg_o == LAST_BANK));

    // R8: extended mode lets register 9 drive the top window
    p_ext_top_r8: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && win == 2'd3) |-> (prg_o == regs[9]));
endmodule

// File: rtl/ext_bank_regfile.sv
module ext_bank_regfile
    import xbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        ext_mode,
    input  logic [1:0]  cpu_win,
    input  logic [2:0]  ppu_slot,
    output logic [7:0]  prg_bank,
    output logic [7:0]  chr_bank,
    output logic [1:0]  mirror
);
    sel_t sel;
    logic data_we;
    logic [NUM_REGS-1:0][BANK_W-1:0] regs;

    xb_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sel_o     (sel),
        .mir_o     (mirror),
        .data_we_o (data_we)
    );

    xb_store u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (data_we),
        .idx    (sel.idx),
        .val    (bank_t'(wr_data)),
        .regs_o (regs)
    );

    xb_chr_map u_chr (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .chr_inv  (sel.chr_inv),
        .slot     (ppu_slot),
        .regs     (regs),
        .chr_o    (chr_bank)
    );

    xb_prg_map u_prg (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .prg_swap (sel.prg_swap),
        .win      (cpu_win),
        .regs     (regs),
        .prg_o    (prg_bank)
    );
endmodule

// File: tb/tb_ext_bank_regfile.sv
module tb_ext_bank_regfile;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ext_mode = 0;
    logic [1:0]  cpu_win = '0;
    logic [2:0]  ppu_slot = '0;
    logic [7:0]  prg_bank, chr_bank;
    logic [1:0]  mirror;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int m_reg [12];
    int m_sel;
    int m_mir;

    always #5 clk = ~clk;

    ext_bank_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_mode(ext_mode), .cpu_win(cpu_win), .ppu_slot(ppu_slot),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror)
    );

    function automatic void model_reset();
        int init [12] = '{0, 2, 4, 5, 6, 7, 0, 1, 254, 255, 255, 255};
        for (int i = 0; i < 12; i++) m_reg[i] = init[i];
        m_sel = 0;
        m_mir = 0;
    endfunction

    function automatic void model_write(input int a, input int d);
        int idx;
        if (a < 32768 || (a & 2) != 0) return;
        if ((a & 16'hE003) == 16'h8000) m_sel = d;
        else if ((a & 16'hE003) == 16'h8001) begin
            idx = m_sel % 16;
            if (idx < 12) m_reg[idx] = d;
        end else if ((a & 16'hE003) == 16'hA000) m_mir = d % 4;
    endfunction

    function automatic int exp_chr(input int s, input bit ext);
        int e;
        int order [8] = '{0, 10, 1, 11, 2, 3, 4, 5};
        e = (m_sel >= 128) ? (s ^ 4) : s;
        if (ext) return m_reg[order[e]];
        if (e < 2) return (m_reg[0] / 2) * 2 + (e % 2);
        if (e < 4) return (m_reg[1] / 2) * 2 + (e % 2);
        return m_reg[e - 2];
    endfunction

    function automatic int exp_prg(input int w, input bit ext);
        bit swap;
        int lo, hi;
        swap = ((m_sel / 64) % 2) == 1;
        lo = ext ? m_reg[8] : 254;
        hi = ext ? m_reg[9] : 255;
        case (w)
            0: return swap ? lo : m_reg[6];
            1: return m_reg[7];
            2: return swap ? m_reg[6] : lo;
            default: return hi;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit we, input int a, input int d, input int w, input int s,
                       input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = 16'(a); wr_data = 8'(d);
        cpu_win = 2'(w); ppu_slot = 3'(s);
        #1;
        cmp(tag, "prg_bank", int'(prg_bank), exp_prg(w, ext_mode));
        cmp(tag, "chr_bank", int'(chr_bank), exp_chr(s, ext_mode));
        cmp(tag, "mirror",   int'(mirror),   m_mir);
        @(posedge clk);
        if (we) model_write(a, d);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        cyc(1, a, d, 0, 0, tag);
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 8; s++) cyc(0, 0, 0, s % 4, s, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R4 reset contents in both schemes
        sweep("R4_std");
        ext_mode = 1;
        sweep("R4_ext");
        ext_mode = 0;

        // load registers 0..7 in standard mode
        for (int i = 0; i < 8; i++) begin
            wr(16'h8000, i, "R3_sel");
            wr(16'h8001, 8'h21 + i * 8'h13, "R3_data");
        end
        sweep("R5_R7_std");
        // R10: registers 8..11 loaded while the flag is clear stay invisible
        for (int i = 8; i < 12; i++) begin
            wr(16'h8000, i, "R10_sel");
            wr(16'h8001, 8'h90 + i * 8'h07, "R10_hidden");
        end
        sweep("R10_hidden");
        ext_mode = 1;
        sweep("R10_R6_R8_ext");

        // R2 swap and invert bits, both schemes
        wr(16'h8000, 8'hC0, "R2_sel");
        sweep("R2_R8_ext_swapped");
        ext_mode = 0;
        sweep("R2_R7_std_swapped");
        wr(16'h8000, 8'h80, "R2_inv_only");
        sweep("R2_R5_inv");
        wr(16'h8000, 8'h40, "R2_swap_only");
        sweep("R2_R7_swap");

        // R1 masked addresses between select and data
        wr(16'h8000, 8'h03, "R1_sel");
        wr(16'h9FFF, 8'h0B, "R1_9fff");
        wr(16'h8002, 8'h0A, "R1_8002");
        wr(16'h0001, 8'h66, "R1_lowaddr");
        wr(16'h8003, 8'h66, "R1_8003");
        wr(16'hC000, 8'h66, "R1_c000");
        wr(16'hE001, 8'h66, "R1_e001");
        wr(16'hA002, 8'h03, "R1_a002");
        wr(16'h8001, 8'h77, "R1_data");
        sweep("R1_after");
        ext_mode = 1;
        sweep("R1_after_ext");

        // R3 indices 12..15 ignored
        for (int i = 12; i < 16; i++) begin
            wr(16'h8000, i, "R3_hi_sel");
            wr(16'h8001, 8'h55, "R3_hi_data");
            sweep("R3_hi_idx");
        end

        // R9 arrangement code
        wr(16'hA000, 8'hFD, "R9_wr1");
        sweep("R9_horz");
        wr(16'hA000, 8'h00, "R9_wr0");
        wr(16'hA002, 8'h01, "R9_masked");
        sweep("R9_vert");

        // R4 again after a mid-run reset
        @(negedge clk) rst = 1;
        @(posedge clk);
        model_reset();
        @(negedge clk) rst = 0;
        ext_mode = 0;
        sweep("R4_rereset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule